// File: doc/BRIEF.md
# MMU Fault Status Capture Unit

This block sits beside a memory management unit and keeps a record of the most recent translation or access fault. Each fault arrives as a one-cycle strobe. With it come the walk level, the access type, the fault type, eight external bus error flags, an address-valid flag, the faulting virtual address and the address space identifier of the access. The block packs these into a 32-bit status word and keeps the address in a separate 32-bit register. Software reads both registers through a simple combinational read port.

A read of the status word marks it as seen. If a second fault lands before that read, the status word carries an overwrite flag. The flag tells the fault handler that the earlier fault was lost and that it must walk the tables by hand. A no-fault control input lets faults update the registers silently, without a trap request. Faults in one exempt address space still raise a trap in that mode. The trap request is a one-cycle pulse.

Top module: `fault_status_unit`

## Requirements
- R1: After reset, the status word and the fault address register both read zero and `trapReq` is low.
- R2: A fault strobe loads the status word in the next cycle. The layout is: bits 9:8 hold the level (0 = context table, 1..3 = page table level 1..3), bits 7:5 the access type (0 user load, 1 supervisor load, 2 user fetch, 3 supervisor fetch, 4 user data store, 5 supervisor data store, 6 user instruction store, 7 supervisor instruction store), bits 4:2 the fault type (0 none, 1 invalid address, 2 protection, 3 privilege, 4 translation, 5 bus access, 6 internal, 7 reserved) and bit 1 the address-valid flag. Bits 31:18 always read zero.
- R3: A fault strobe loads the full 32-bit virtual address into the fault address register. Reading with `rdSel`=1 returns that register.
- R4: A fault that arrives while an earlier fault's status is still unread sets bit 0 (overwrite). The status fields then show the newest fault.
- R5: A status read (`rdEn`=1, `rdSel`=0) returns the current word in the same cycle. It clears bit 0 and marks the status as read, so the next fault does not set bit 0. A read of the address register leaves the unread state as it is.
- R6: When a fault strobe and a status read fall in the same cycle, the read returns the old word. The new fault is captured with bit 0 clear, and it counts as unread.
- R7: With `noFaultEn`=0, every fault drives `trapReq` high for exactly the one cycle that follows the strobe.
- R8: With `noFaultEn`=1, faults still update both registers. `trapReq` stays low, except for faults whose `faultAsi` equals 9, which trap as in R7.
- R9: The eight bus error flags land in status bits 17:10, with flag bit i in status bit 10+i. These include bus error at bit 10, timeout at bit 11, uncorrectable error at bit 12, undefined error at bit 13, parity at bit 14, store buffer error at bit 15 and control space access error at bit 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| noFaultEn | input | 1 | No-fault mode: suppress traps except for the exempt ASI |
| faultStrobe | input | 1 | One-cycle fault event |
| faultLevel | input | 2 | Walk level of the fault |
| faultAccType | input | 3 | Access type code |
| faultType | input | 3 | Fault type code |
| busErrFlags | input | 8 | External bus error flags |
| faultAddrValid | input | 1 | Faulting address is meaningful |
| faultVaddr | input | 32 | Faulting virtual address |
| faultAsi | input | 8 | Address space identifier of the access |
| rdEn | input | 1 | Register read request |
| rdSel | input | 1 | 0 = status word, 1 = fault address |
| rdData | output | 32 | Read data, combinational |
| trapReq | output | 1 | One-cycle trap request to the CPU |

## Verification
On every cycle, the assertions check four things. Each captured field and the address match the strobe that preceded them. A status read, with or without a coinciding fault, leaves the overwrite bit clear. Every trap pulse traces back to a strobe that was allowed to trap. The bench scenarios cover what depends on the history of faults and reads: the unread-then-overwritten sequence, an address read that leaves the unread state alone, the same-cycle race between a fault and a read, the exempt address space in no-fault mode, and the placement of each bus error flag.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  localparam int STATUS_W = 32;
  localparam int EBE_W    = 8;
  localparam int EBE_LSB  = 10;
  localparam int EBE_MSB  = EBE_LSB + EBE_W - 1;

  typedef struct packed {
    logic capture;
    logic setOw;
    logic clearOw;
  } ctrlStrobes_t;
endpackage

// File: rtl/fsc_ctrl.sv
module fsc_ctrl
  import fsc_pkg::*;
#(
  parameter int ASI_W      = 8,
  parameter int EXEMPT_ASI = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             faultStrobe,
  input  logic             statusRead,
  input  logic             noFaultEn,
  input  logic [ASI_W-1:0] faultAsi,
  output ctrlStrobes_t     strb,
  output logic             trapReq
);
  localparam logic [ASI_W-1:0] EXEMPT = ASI_W'(EXEMPT_ASI);

  logic pending;
  logic trapAllowed;

  assign trapAllowed  = !noFaultEn || (faultAsi == EXEMPT);
  assign strb.capture = faultStrobe;
  assign strb.setOw   = faultStrobe && pending && !statusRead;
  assign strb.clearOw = statusRead;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      trapReq <= 1'b0;
    end else begin
      if (faultStrobe)     pending <= 1'b1;
      else if (statusRead) pending <= 1'b0;
      trapReq <= faultStrobe && trapAllowed;
    end
  end

  // R7: a trap pulse always follows a strobe
  assert_trap_follows_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trapReq |-> $past(faultStrobe));

  // R8: in no-fault mode only the exempt space traps
  assert_nofault_exempt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trapReq |-> ($past(!noFaultEn) || $past(faultAsi) == EXEMPT));
endmodule

// File: rtl/fsc_datapath.sv
module fsc_datapath
  import fsc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  ctrlStrobes_t        strb,
  input  logic [1:0]          faultLevel,
  input  logic [2:0]          faultAccType,
  input  logic [2:0]          faultType,
  input  logic [EBE_W-1:0]    busErrFlags,
  input  logic                faultAddrValid,
  input  logic [ADDR_W-1:0]   faultVaddr,
  output logic [STATUS_W-1:0] statusWord,
  output logic [ADDR_W-1:0]   faultAddr
);
  localparam int RESV_W = STATUS_W - EBE_MSB - 1;

  logic [EBE_W-1:0] ebeQ;
  logic [1:0]       levelQ;
  logic [2:0]       accQ;
  logic [2:0]       typeQ;
  logic             favQ;
  logic             owQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ebeQ      <= '0;
      levelQ    <= '0;
      accQ      <= '0;
      typeQ     <= '0;
      favQ      <= 1'b0;
      owQ       <= 1'b0;
      faultAddr <= '0;
    end else if (strb.capture) begin
      ebeQ      <= busErrFlags;
      levelQ    <= faultLevel;
      accQ      <= faultAccType;
      typeQ     <= faultType;
      favQ      <= faultAddrValid;
      owQ       <= strb.setOw;
      faultAddr <= faultVaddr;
    end else if (strb.clearOw) begin
      owQ <= 1'b0;
    end
  end

  assign statusWord = {{RESV_W{1'b0}}, ebeQ, levelQ, accQ, typeQ, favQ, owQ};

  // R2: captured fields reflect the preceding strobe
  assert_fields_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    strb.capture |=> (statusWord[9:2] == {$past(faultLevel), $past(faultAccType), $past(faultType)})
                     && statusWord[1] == $past(faultAddrValid));

  // R3: address capture
  assert_addr_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strb.capture |=> faultAddr == $past(faultVaddr));

  // R9: bus error flags land in their field
  assert_ebe_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
    strb.capture |=> statusWord[EBE_MSB:EBE_LSB] == $past(busErrFlags));

  // R5 / R6: a status read always leaves the overwrite bit clear
  assert_read_clears_ow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strb.clearOw |=> !statusWord[0]);
endmodule

// File: rtl/fault_status_unit.sv
module fault_status_unit
  import fsc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int ASI_W      = 8,
  parameter int EXEMPT_ASI = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              noFaultEn,
  input  logic              faultStrobe,
  input  logic [1:0]        faultLevel,
  input  logic [2:0]        faultAccType,
  input  logic [2:0]        faultType,
  input  logic [7:0]        busErrFlags,
  input  logic              faultAddrValid,
  input  logic [ADDR_W-1:0] faultVaddr,
  input  logic [ASI_W-1:0]  faultAsi,
  input  logic              rdEn,
  input  logic              rdSel,
  output logic [31:0]       rdData,
  output logic              trapReq
);
  ctrlStrobes_t        strb;
  logic                statusRead;
  logic [STATUS_W-1:0] statusWord;
  logic [ADDR_W-1:0]   faultAddr;

  assign statusRead = rdEn && !rdSel;

  fsc_ctrl #(.ASI_W(ASI_W), .EXEMPT_ASI(EXEMPT_ASI)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .faultStrobe(faultStrobe), .statusRead(statusRead),
    .noFaultEn(noFaultEn), .faultAsi(faultAsi), .strb(strb), .trapReq(trapReq));

  fsc_datapath #(.ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .strb(strb), .faultLevel(faultLevel),
    .faultAccType(faultAccType), .faultType(faultType), .busErrFlags(busErrFlags),
    .faultAddrValid(faultAddrValid), .faultVaddr(faultVaddr),
    .statusWord(statusWord), .faultAddr(faultAddr));

  assign rdData = rdSel ? 32'(faultAddr) : statusWord;

  // R1: registers are zero in the first cycle after reset
  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(!rst_n) |-> (statusWord == '0 && faultAddr == '0 && !trapReq));
endmodule

// File: tb/fault_status_unit_tb_top.sv
`timescale 1ns/1ps
module fault_status_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        noFaultEn = 1'b0;
  logic        faultStrobe = 1'b0;
  logic [1:0]  faultLevel = '0;
  logic [2:0]  faultAccType = '0;
  logic [2:0]  faultType = '0;
  logic [7:0]  busErrFlags = '0;
  logic        faultAddrValid = 1'b0;
  logic [31:0] faultVaddr = '0;
  logic [7:0]  faultAsi = '0;
  logic        rdEn = 1'b0;
  logic        rdSel = 1'b0;
  logic [31:0] rdData;
  logic        trapReq;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  fault_status_unit dut_i (.*);

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] mkStatus(logic [7:0] ebe, logic [1:0] lvl, logic [2:0] at,
                                           logic [2:0] ft, logic fav, logic ow);
    return {14'b0, ebe, lvl, at, ft, fav, ow};
  endfunction

  task automatic doFault(logic [1:0] lvl, logic [2:0] at, logic [2:0] ft, logic [7:0] ebe,
                         logic fav, logic [31:0] va, logic [7:0] asi);
    @(negedge clk);
    faultStrobe = 1'b1; faultLevel = lvl; faultAccType = at; faultType = ft;
    busErrFlags = ebe; faultAddrValid = fav; faultVaddr = va; faultAsi = asi;
    @(negedge clk);
    faultStrobe = 1'b0;
  endtask

  task automatic readReg(logic sel, output logic [31:0] val);
    @(negedge clk);
    rdEn = 1'b1; rdSel = sel;
    #1 val = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic testReset();
    logic [31:0] v;
    check("R1 trap", {31'b0, trapReq}, 32'd0);
    readReg(1'b0, v); check("R1 status", v, 32'd0);
    readReg(1'b1, v); check("R1 addr", v, 32'd0);
  endtask

  task automatic testSingle();
    logic [31:0] v;
    doFault(2'd2, 3'd4, 3'd2, 8'h00, 1'b1, 32'hDEAD_BEEF, 8'h0B);
    check("R7 trap high", {31'b0, trapReq}, 32'd1);
    @(negedge clk);
    check("R7 trap single", {31'b0, trapReq}, 32'd0);
    readReg(1'b1, v); check("R3 addr", v, 32'hDEAD_BEEF);
    readReg(1'b0, v); check("R2 status", v, mkStatus(8'h00, 2'd2, 3'd4, 3'd2, 1'b1, 1'b0));
  endtask

  task automatic testOverwrite();
    logic [31:0] v;
    doFault(2'd1, 3'd1, 3'd1, 8'h00, 1'b1, 32'h1000_0000, 8'h0B);
    readReg(1'b1, v); check("R5 addr read", v, 32'h1000_0000);
    doFault(2'd3, 3'd7, 3'd3, 8'h00, 1'b0, 32'h2000_0004, 8'h0B);
    readReg(1'b0, v); check("R4 overwrite", v, mkStatus(8'h00, 2'd3, 3'd7, 3'd3, 1'b0, 1'b1));
    readReg(1'b0, v); check("R5 cleared", v, mkStatus(8'h00, 2'd3, 3'd7, 3'd3, 1'b0, 1'b0));
    doFault(2'd0, 3'd2, 3'd4, 8'h00, 1'b1, 32'h3000_0008, 8'h0B);
    readReg(1'b0, v); check("R5 no ow after read", v, mkStatus(8'h00, 2'd0, 3'd2, 3'd4, 1'b1, 1'b0));
  endtask

  task automatic testRace();
    logic [31:0] v;
    doFault(2'd1, 3'd3, 3'd5, 8'h00, 1'b1, 32'h4000_0000, 8'h0B);
    @(negedge clk);
    faultStrobe = 1'b1; faultLevel = 2'd2; faultAccType = 3'd5; faultType = 3'd6;
    busErrFlags = 8'h00; faultAddrValid = 1'b1; faultVaddr = 32'h5000_0000;
    rdEn = 1'b1; rdSel = 1'b0;
    #1 check("R6 old word", rdData, mkStatus(8'h00, 2'd1, 3'd3, 3'd5, 1'b1, 1'b0));
    @(negedge clk);
    faultStrobe = 1'b0; rdEn = 1'b0;
    readReg(1'b1, v); check("R6 new addr", v, 32'h5000_0000);
    doFault(2'd0, 3'd0, 3'd1, 8'h00, 1'b0, 32'h6000_0000, 8'h0B);
    readReg(1'b0, v); check("R6 still unread", v, mkStatus(8'h00, 2'd0, 3'd0, 3'd1, 1'b0, 1'b1));
    readReg(1'b0, v);
  endtask

  task automatic testNoFault();
    logic [31:0] v;
    noFaultEn = 1'b1;
    doFault(2'd3, 3'd5, 3'd2, 8'h00, 1'b1, 32'h7000_0010, 8'h0B);
    check("R8 no trap", {31'b0, trapReq}, 32'd0);
    readReg(1'b1, v); check("R8 addr updated", v, 32'h7000_0010);
    readReg(1'b0, v); check("R8 status updated", v, mkStatus(8'h00, 2'd3, 3'd5, 3'd2, 1'b1, 1'b0));
    doFault(2'd1, 3'd0, 3'd1, 8'h00, 1'b1, 32'h7000_0020, 8'h09);
    check("R8 exempt asi traps", {31'b0, trapReq}, 32'd1);
    @(negedge clk);
    check("R8 exempt single", {31'b0, trapReq}, 32'd0);
    readReg(1'b0, v);
    noFaultEn = 1'b0;
  endtask

  task automatic testBusErr();
    logic [31:0] v;
    for (int i = 0; i < 8; i++) begin
      doFault(2'd0, 3'd0, 3'd5, 8'(1 << i), 1'b1, 32'h8000_0000 + i, 8'h0B);
      readReg(1'b0, v);
      check("R9 flag position", v, 32'(1) << (10 + i) | mkStatus(8'h00, 2'd0, 3'd0, 3'd5, 1'b1, 1'b0));
    end
    doFault(2'd0, 3'd0, 3'd5, 8'hA5, 1'b0, 32'h0, 8'h0B);
    readReg(1'b0, v);
    check("R9 mixed flags R2 reserved", v, mkStatus(8'hA5, 2'd0, 3'd0, 3'd5, 1'b0, 1'b0));
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testSingle();
    testOverwrite();
    testRace();
    testNoFault();
    testBusErr();
    finished = 1;
    report();
  end

  initial begin
    #50000;
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      report();
    end
  end
endmodule